// File: doc/BRIEF.md
# Three-Phase Sine-Triangle Gate Pattern Generator

This block produces the six switch commands of a two-level, three-leg inverter bridge. One free-running phase accumulator, advanced by a programmable step every clock, addresses three cosine tables. The three table addresses are spaced one third of a turn apart. Each table value is scaled by a programmable amplitude and shifted up to mid-scale, so that it becomes a unipolar reference level.

A single up/down triangle counter serves as the carrier for all three legs. At each carrier trough every leg captures its reference and holds it for the whole carrier period. The leg command is high while the carrier is below the held level. The command then passes through a dead-band stage. That stage drops the conducting switch at once and turns the opposite switch of the same leg on only after a fixed number of quiet cycles.

A start pulse sets the generator running and a stop pulse halts it. While halted, the block clears its counters and forces all six switch commands off.

Top module: `spwm3_gen`

## Requirements
- R1: After reset, and on every cycle after the run state has been cleared, all six gate outputs are 0 and the phase and carrier counters are cleared. A stop pulse clears the run state and a start pulse sets it. When start and stop are asserted in the same cycle, stop wins.
- R2: The carrier counts 0, 1, …, CAR_MAX and then back down to 1, so one carrier period is 2·CAR_MAX clocks (500 clocks at the defaults).
- R3: A leg's command is high on exactly the clocks where the carrier is below that leg's held level r. With 1 ≤ r ≤ CAR_MAX, the command is high for 2r−1 clocks of each period.
- R4: The reference level of a leg is CAR_MAX/2 + (amp/512)·(CAR_MAX/2)·cos(θ). Here amp is an unsigned number with 9 fraction bits, so 512 means 1.0 and 420 is the nominal 0.82.
- R5: Leg 0 uses the angle θ, leg 1 uses θ−120° and leg 2 uses θ+120°. The three references therefore sum to 3·CAR_MAX/2.
- R6: Each leg samples its reference only when the carrier is at 0 and keeps it unchanged for the rest of the period, so each leg gives at most one high pulse per period.
- R7: The reference is clamped to the range 0 to CAR_MAX+1. An amplitude above 1.0 therefore gives a command that is high for the whole period (or low for the whole period) without any error indication.
- R8: The phase angle advances by freq_step/2^PH_W of a turn every clock while running. A step of 0 holds the angle. Because the angle is cleared while halted, a restart begins at θ = 0.
- R9: Gate hi of a leg follows a high command and gate lo follows a low command. A switch turns off one clock after its command is removed. The opposite switch turns on only after exactly DEAD further clocks in which both are off (DEAD = 8 by default).
- R10: gate_hi[i] and gate_lo[i] are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that sets the run state |
| stop | input | 1 | Pulse that clears the run state (wins over start) |
| amp | input | AMP_W (10) | Modulation amplitude, 9 fraction bits |
| freq_step | input | STEP_W (16) | Phase increment per clock |
| gate_hi | output | 3 | High-side switch command per leg |
| gate_lo | output | 3 | Low-side switch command per leg |

## Verification
A wrong carrier state shows at the ports within one period. The spacing between successive rising edges of a leg stops being 500 clocks, or the high time stops matching 2r−1 minus the dead band. A held reference that changes in mid-period shows as a second pulse in the same period, and a bad table offset breaks the balance of the three duty cycles. A dead-band counter fault appears as an off gap other than DEAD clocks at the next command edge, or as an overlap of the two switches of a leg. Stop handling errors show within a few clocks as gate activity while halted.

// File: rtl/spwm3_pkg.sv
package spwm3_pkg;
  localparam int NUM_LEGS = 3;

  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } car_dir_e;
endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int CAR_MAX = 250,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [CW-1:0] count,
  output logic          trough
);
  import spwm3_pkg::*;

  localparam logic [CW-1:0] TOP_M1 = CW'(CAR_MAX - 1);

  car_dir_e dir;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      count <= '0;
      dir   <= CNT_UP;
    end else begin
      unique case (dir)
        CNT_UP: begin
          count <= count + 1'b1;
          if (count == TOP_M1) dir <= CNT_DOWN;
        end
        CNT_DOWN: begin
          count <= count - 1'b1;
          if (count == CW'(1)) dir <= CNT_UP;
        end
        default: dir <= CNT_UP;
      endcase
    end
  end

  assign trough = run && (count == '0);
endmodule

// File: rtl/spwm_cos_rom.sv
module spwm_cos_rom #(
  parameter int AW = 10,
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic [AW-1:0]        addr,
  output logic signed [DW-1:0] data
);
  localparam int  DEPTH = 2 ** AW;
  localparam real PEAK  = real'((2 ** (DW - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'($rtoi($floor(PEAK * $cos(TWO_PI * real'(i) / real'(DEPTH)) + 0.5)));
    end
  end

  always_ff @(posedge clk) begin
    data <= mem[addr];
  end
endmodule

// File: rtl/spwm_deadband.sv
module spwm_deadband #(
  parameter int DEAD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic cmd,
  output logic hi,
  output logic lo
);
  localparam int DCW = (DEAD > 0) ? $clog2(DEAD + 1) : 1;
  localparam logic [DCW-1:0] DLIM = DCW'(DEAD);

  logic           cmd_q;
  logic [DCW-1:0] quiet;
  logic           settled;

  assign settled = (quiet == DLIM);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cmd_q <= 1'b0;
      quiet <= '0;
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else begin
      if (cmd != cmd_q) begin
        cmd_q <= cmd;
        quiet <= '0;
      end else if (!settled) begin
        quiet <= quiet + 1'b1;
      end
      hi <= cmd_q && settled;
      lo <= !cmd_q && settled;
    end
  end
endmodule

// File: rtl/spwm_leg.sv
module spwm_leg #(
  parameter int CAR_MAX  = 250,
  parameter int CW       = 8,
  parameter int RW       = 9,
  parameter int COS_W    = 12,
  parameter int AMP_W    = 10,
  parameter int AMP_FRAC = 9,
  parameter int DEAD     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    trough,
  input  logic [CW-1:0]           carrier,
  input  logic [AMP_W-1:0]        amp,
  input  logic signed [COS_W-1:0] cos_val,
  output logic [RW-1:0]           held_ref,
  output logic                    gate_hi,
  output logic                    gate_lo
);
  localparam int HALF = CAR_MAX / 2;
  localparam int PW   = AMP_W + COS_W + RW + 3;
  localparam int SH   = AMP_FRAC + COS_W - 1;
  localparam logic signed [PW-1:0] CEIL = PW'(CAR_MAX + 1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] level;
  logic [RW-1:0]        ref_next;
  logic [RW-1:0]        ref_q;
  logic [RW-1:0]        cmp_ref;
  logic                 cmd;

  always_comb begin
    prod  = PW'($signed({1'b0, amp})) * PW'(cos_val) * PW'(HALF);
    level = (prod >>> SH) + PW'(HALF);
    if (level < 0)         ref_next = '0;
    else if (level > CEIL) ref_next = RW'(CAR_MAX + 1);
    else                   ref_next = level[RW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= '0;
    else     ref_q <= ref_next;
  end

  always_ff @(posedge clk) begin
    if (rst || !run)  held_ref <= '0;
    else if (trough)  held_ref <= ref_q;
  end

  assign cmp_ref = trough ? ref_q : held_ref;

  always_ff @(posedge clk) begin
    if (rst || !run) cmd <= 1'b0;
    else             cmd <= ({1'b0, carrier} < cmp_ref);
  end

  spwm_deadband #(.DEAD(DEAD)) u_db (
    .clk (clk),
    .rst (rst),
    .run (run),
    .cmd (cmd),
    .hi  (gate_hi),
    .lo  (gate_lo)
  );
endmodule

// File: rtl/spwm3_gen.sv
module spwm3_gen #(
  parameter int CAR_MAX  = 250,
  parameter int PH_W     = 16,
  parameter int STEP_W   = 16,
  parameter int LUT_AW   = 10,
  parameter int COS_W    = 12,
  parameter int AMP_W    = 10,
  parameter int AMP_FRAC = 9,
  parameter int DEAD     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [AMP_W-1:0]  amp,
  input  logic [STEP_W-1:0] freq_step,
  output logic [2:0]        gate_hi,
  output logic [2:0]        gate_lo
);
  import spwm3_pkg::*;

  localparam int CW     = $clog2(CAR_MAX + 1);
  localparam int RW     = CW + 1;
  localparam int THIRD  = ((2 ** PH_W) + 1) / 3;
  localparam int ROUNDV = 2 ** (PH_W - LUT_AW - 1);

  logic                  run;
  logic [PH_W-1:0]       phase;
  logic [CW-1:0]         carrier;
  logic                  trough;
  logic [NUM_LEGS*RW-1:0] held_flat;

  always_ff @(posedge clk) begin
    if (rst)        run <= 1'b0;
    else if (stop)  run <= 1'b0;
    else if (start) run <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) phase <= '0;
    else             phase <= phase + PH_W'(freq_step);
  end

  spwm_carrier #(.CAR_MAX(CAR_MAX), .CW(CW)) u_car (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .count  (carrier),
    .trough (trough)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    localparam logic [PH_W-1:0] SHIFT = (g == 0) ? PH_W'(0)
                                      : (g == 1) ? PH_W'((2 ** PH_W) - THIRD)
                                      : PH_W'(THIRD);
    logic [PH_W-1:0]         ang;
    logic signed [COS_W-1:0] cos_val;
    logic [RW-1:0]           held;

    assign ang = phase + SHIFT + PH_W'(ROUNDV);

    spwm_cos_rom #(.AW(LUT_AW), .DW(COS_W)) u_rom (
      .clk  (clk),
      .addr (ang[PH_W-1 -: LUT_AW]),
      .data (cos_val)
    );

    spwm_leg #(
      .CAR_MAX(CAR_MAX), .CW(CW), .RW(RW), .COS_W(COS_W),
      .AMP_W(AMP_W), .AMP_FRAC(AMP_FRAC), .DEAD(DEAD)
    ) u_leg (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .trough   (trough),
      .carrier  (carrier),
      .amp      (amp),
      .cos_val  (cos_val),
      .held_ref (held),
      .gate_hi  (gate_hi[g]),
      .gate_lo  (gate_lo[g])
    );

    assign held_flat[g*RW +: RW] = held;
  end
endmodule

// File: rtl/spwm3_gen_chk.sv
module spwm3_gen_chk #(
  parameter int CAR_MAX = 250,
  parameter int CW      = 8,
  parameter int RW      = 9,
  parameter int DEAD    = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic [CW-1:0] carrier,
  input logic [3*RW-1:0] held_flat,
  input logic [2:0]    gate_hi,
  input logic [2:0]    gate_lo
);
  // R1: halted means all switches off on the next clock
  p_off_when_halted_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

  // R2: carrier stays inside its range
  p_carrier_range_r2: assert property (@(posedge clk) disable iff (rst)
    carrier <= CW'(CAR_MAX));

  // R2: carrier moves by exactly one step each running clock
  p_carrier_step_r2: assert property (@(posedge clk) disable iff (rst)
    run |=> (carrier == $past(carrier) + 1'b1 || carrier == $past(carrier) - 1'b1));

  // R6: held levels only change at a trough or when halted
  p_hold_between_troughs_r6: assert property (@(posedge clk) disable iff (rst)
    (run && carrier != '0) |=> $stable(held_flat));

  // R10: no leg has both switches on
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  for (genvar g = 0; g < 3; g++) begin : g_leg_chk
    // R7: held level never exceeds the clamp ceiling
    p_ref_clamp_r7: assert property (@(posedge clk) disable iff (rst)
      held_flat[g*RW +: RW] <= RW'(CAR_MAX + 1));

    if (DEAD > 0) begin : g_dead
      // R9: a switch turns on only after a cycle in which its partner was off
      p_lo_after_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo[g]) |-> !$past(gate_hi[g]));
      p_hi_after_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi[g]) |-> !$past(gate_lo[g]));
    end
  end
endmodule

bind spwm3_gen spwm3_gen_chk #(
  .CAR_MAX(CAR_MAX), .CW(CW), .RW(RW), .DEAD(DEAD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .carrier   (carrier),
  .held_flat (held_flat),
  .gate_hi   (gate_hi),
  .gate_lo   (gate_lo)
);

// File: tb/spwm3_gen_bench.sv
module spwm3_gen_bench;
  localparam int  CM  = 250;
  localparam int  DT  = 8;
  localparam int  PER = 2 * CM;
  localparam real PI  = 3.141592653589793;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic [9:0] amp = '0;
  logic [15:0] freq_step = '0;
  logic [2:0] gate_hi;
  logic [2:0] gate_lo;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int overlap = 0;
  int hcnt [3];
  int lcnt [3];
  int rises[3];

  spwm3_gen u_spwm3_gen (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop      (stop),
    .amp       (amp),
    .freq_step (freq_step),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && ((gate_hi & gate_lo) != 3'b000)) overlap++;
    if (cyc > 190000) begin
      n_chk++;
      n_err++;
      $display("FAIL all-R watchdog: cycles=%0d expected < 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic near(string req, string what, int act, real exp, real tol);
    real d;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    chk(d <= tol, req, what, act, $rtoi(exp));
  endtask

  function automatic real lvl(int a, real deg);
    return CM / 2.0 + (real'(a) / 512.0) * (CM / 2.0) * $cos(deg * PI / 180.0);
  endfunction

  function automatic real hi_exp(real r);
    real n;
    if (r >= CM + 1.0) return real'(PER);
    n = 2.0 * r - 1.0;
    if (n <= DT) return 0.0;
    return n - DT;
  endfunction

  function automatic real lo_exp(real r);
    real n;
    real l;
    if (r <= 0.0) return real'(PER);
    if (r >= CM + 1.0) return 0.0;
    n = 2.0 * r - 1.0;
    l = PER - n;
    if (l <= DT) return 0.0;
    return l - DT;
  endfunction

  task automatic measure(int n);
    logic [2:0] prev;
    for (int k = 0; k < 3; k++) begin
      hcnt[k] = 0; lcnt[k] = 0; rises[k] = 0;
    end
    @(negedge clk);
    prev = gate_hi;
    repeat (n) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        if (gate_hi[k]) hcnt[k]++;
        if (gate_lo[k]) lcnt[k]++;
        if (gate_hi[k] && !prev[k]) rises[k]++;
      end
      prev = gate_hi;
    end
  endtask

  task automatic go(int a, int s);
    @(negedge clk);
    amp = 10'(a);
    freq_step = 16'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic t_reset();
    int bad = 0;
    repeat (5) @(negedge clk);
    if (gate_hi != 3'b000 || gate_lo != 3'b000) bad++;
    rst = 1'b0;
    repeat (600) begin
      @(negedge clk);
      if (gate_hi != 3'b000 || gate_lo != 3'b000) bad++;
    end
    chk(bad == 0, "R1", "outputs active during or after reset before start", bad, 0);
  endtask

  task automatic t_mid_level();
    halt();
    go(0, 0);
    repeat (1200) @(negedge clk);
    measure(PER);
    for (int k = 0; k < 3; k++) begin
      near("R3", "hi count at zero amplitude", hcnt[k], hi_exp(CM / 2.0), 1.0);
      near("R3", "lo count at zero amplitude", lcnt[k], lo_exp(CM / 2.0), 1.0);
    end
  endtask

  task automatic t_period();
    int t0;
    int guard;
    guard = 0;
    do begin @(negedge clk); guard++; end while (gate_hi[0] && guard < 2000);
    do begin @(negedge clk); guard++; end while (!gate_hi[0] && guard < 2000);
    t0 = cyc;
    do begin @(negedge clk); guard++; end while (gate_hi[0] && guard < 2000);
    do begin @(negedge clk); guard++; end while (!gate_hi[0] && guard < 2000);
    chk(cyc - t0 == PER, "R2", "spacing of successive rising edges", cyc - t0, PER);
  endtask

  task automatic t_deadband();
    int gap;
    int guard;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!gate_hi[0] && guard < 2000);
    do begin @(negedge clk); guard++; end while (gate_hi[0] && guard < 2000);
    gap = 0;
    while (!gate_lo[0] && guard < 2000) begin gap++; guard++; @(negedge clk); end
    chk(gap == DT, "R9", "off gap hi->lo", gap, DT);
    do begin @(negedge clk); guard++; end while (gate_lo[0] && guard < 2000);
    gap = 0;
    while (!gate_hi[0] && guard < 2000) begin gap++; guard++; @(negedge clk); end
    chk(gap == DT, "R9", "off gap lo->hi", gap, DT);
  endtask

  task automatic t_full_scale();
    halt();
    go(512, 0);
    repeat (1200) @(negedge clk);
    measure(PER);
    near("R4", "leg0 hi count at amp 1.0", hcnt[0], hi_exp(lvl(512, 0.0)), 6.0);
    near("R5", "leg1 hi count at -120 deg", hcnt[1], hi_exp(lvl(512, -120.0)), 6.0);
    near("R5", "leg2 hi count at +120 deg", hcnt[2], hi_exp(lvl(512, 120.0)), 6.0);
    near("R5", "leg1 vs leg2 symmetry", hcnt[1], real'(hcnt[2]), 4.0);
  endtask

  task automatic t_nominal();
    @(negedge clk);
    amp = 10'd420;
    repeat (1200) @(negedge clk);
    measure(PER);
    near("R4", "leg0 hi count at nominal amp", hcnt[0], hi_exp(lvl(420, 0.0)), 6.0);
    near("R4", "leg0 lo count at nominal amp", lcnt[0], lo_exp(lvl(420, 0.0)), 6.0);
  endtask

  task automatic t_overmod();
    @(negedge clk);
    amp = 10'd1023;
    repeat (1200) @(negedge clk);
    measure(PER);
    chk(hcnt[0] == PER, "R7", "leg0 hi saturates full width", hcnt[0], PER);
    chk(lcnt[0] == 0, "R7", "leg0 lo stays off when saturated", lcnt[0], 0);
    chk(hcnt[1] == 0, "R7", "leg1 hi stays off at floor", hcnt[1], 0);
    chk(hcnt[2] == 0, "R7", "leg2 hi stays off at floor", hcnt[2], 0);
  endtask

  task automatic t_rotation();
    int total = 0;
    int amin = PER;
    int amax = 0;
    int redges = 0;
    halt();
    go(420, 13);
    repeat (1200) @(negedge clk);
    for (int w = 0; w < 20; w++) begin
      measure(PER - 1);
      total += hcnt[0] + hcnt[1] + hcnt[2];
      if (hcnt[0] < amin) amin = hcnt[0];
      if (hcnt[0] > amax) amax = hcnt[0];
      redges += rises[0];
    end
    near("R5", "sum of three legs over rotation", total, 20.0 * 3.0 * (CM - DT - 1.0), 150.0);
    chk(amax - amin > 200, "R8", "leg0 duty swing while rotating", amax - amin, 200);
    chk(redges >= 18 && redges <= 21, "R6", "one pulse per carrier period", redges, 20);
  endtask

  task automatic t_stop_restart();
    int bad = 0;
    halt();
    repeat (2) @(negedge clk);
    repeat (1000) begin
      @(negedge clk);
      if (gate_hi != 3'b000 || gate_lo != 3'b000) bad++;
    end
    chk(bad == 0, "R1", "outputs active after stop", bad, 0);
    go(512, 0);
    repeat (1200) @(negedge clk);
    measure(PER);
    near("R8", "restart begins at zero angle", hcnt[0], hi_exp(lvl(512, 0.0)), 6.0);
  endtask

  task automatic t_start_stop_together();
    int bad = 0;
    halt();
    @(negedge clk);
    start = 1'b1;
    stop = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop = 1'b0;
    repeat (700) begin
      @(negedge clk);
      if (gate_hi != 3'b000 || gate_lo != 3'b000) bad++;
    end
    chk(bad == 0, "R1", "stop wins over simultaneous start", bad, 0);
  endtask

  initial begin
    t_reset();
    t_mid_level();
    t_period();
    t_deadband();
    t_full_scale();
    t_nominal();
    t_overmod();
    t_rotation();
    t_stop_restart();
    t_start_stop_together();
    chk(overlap == 0, "R10", "cycles with both switches of a leg on", overlap, 0);
    summary();
    $finish;
  end
endmodule